// File: doc/BRIEF.md
# Eight-Pin I/O Port with Peripheral Override Logic

This block is an eight-pin general-purpose I/O port. Software sets three per-pin registers through a small address/write-enable/data bus: a direction register, an output/pull-up register and a pin-change mask. A read-only readback register returns each pad's level after synchronization. On each pin, override logic lets an attached peripheral take control of four things: the direction, the pull-up, the output value and the digital input enable. Each of these has an override-enable and an override-value.

The upper four pins (bits 7..4) carry timer compare outputs. The lower four pins carry the serial peripheral link:

| Bit | Signal |
|-----|--------|
| 3 | MISO |
| 2 | MOSI |
| 1 | SCK |
| 0 | SS (active low) |

Which SPI overrides apply depends on a link-enable input and a master/slave mode input. Each pin also drives a pin-change source. That source is qualified by the pin's mask bit and a group enable.

A low-power input-off request turns off the pad input buffers. The exception is any pin whose pin-change source is armed: its input stays on. The SPI and timer engines and the interrupt controller sit outside this block. They connect through the override and readback ports.

Top module: `gpio_alt_port`

## Requirements
- R1: After reset, the following all read 0: the direction, output/pull-up and mask registers, and the readback. As a result every `padOe` and `padPullUp` bit is 0.
- R2: The bus address decodes as follows.
  - Address 0 selects the direction register, 1 the output/pull-up register and 3 the mask register. Each can be both written and read.
  - Address 2 selects the readback, which is read-only. A write to address 2 changes no register.
  - Addresses 4 to 7 read 0.
  - A write takes effect on the clock edge where `busWe` is 1.
  - `busRdata` is combinational.
- R3: A pin with no active override behaves as a plain I/O pin:
  - `padOe` equals its direction bit.
  - `padOut` equals its output bit.
  - `padPullUp` is 1 only when the direction bit is 0, the output bit is 1 and `pullUpDisable` is 0.
- R4: When `spiEnable` is 1 and `spiMaster` is 1:
  - Pin 3 is forced to input, and its pull-up still follows rule R3.
  - Pin 2 outputs `spiMosiOut` and pin 1 outputs `spiSckOut`.
  - Pins 2 and 1 keep their direction from the direction register.
- R5: When `spiEnable` is 1 and `spiMaster` is 0:
  - Pins 2, 1 and 0 are forced to input, and their pull-ups still follow rule R3.
  - Pin 3 outputs `spiMisoOut`, and its direction comes from direction bit 3.
- R6: `padOut[0]` always equals output-register bit 0. The SS pin never has its output value overridden.
- R7: For k in 0..3, `cmpEnable[k]` = 1 makes `padOut[4+k]` equal `cmpValue[k]`. Direction and pull-up of pins 7..4 always follow R3. The compare output therefore reaches the pad only when the direction bit is set.
- R8: Each pad input passes through two flops. The readback and the SPI inputs show `padIn` two rising edges after it is sampled.
- R9: While `inputsOff` is 1, a pin's synchronizer input is 0, unless that pin's mask bit is 1 and `pcGroupEn` is 1.
- R10: `pinChange[i]` equals synchronized bit i AND mask bit i AND `pcGroupEn`.
- R11: `spiSlaveSel` is 1 only when all three hold: `spiEnable` is 1, `spiMaster` is 0, and synchronized pin 0 is 0.
- R12: The synchronized pins are routed to the SPI inputs as follows: pin 3 to `spiMisoIn`, pin 2 to `spiMosiIn` and pin 1 to `spiSckIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 3 | Register address |
| busWe | input | 1 | Write enable |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| pullUpDisable | input | 1 | Global pull-up disable |
| pcGroupEn | input | 1 | Pin-change group enable |
| inputsOff | input | 1 | Low-power request to turn off input buffers |
| spiEnable | input | 1 | Serial link enabled |
| spiMaster | input | 1 | 1 = master mode, 0 = slave mode |
| spiMisoOut | input | 1 | Slave data output from the link |
| spiMosiOut | input | 1 | Master data output from the link |
| spiSckOut | input | 1 | Master clock output from the link |
| spiMisoIn | output | 1 | Master data input to the link |
| spiMosiIn | output | 1 | Slave data input to the link |
| spiSckIn | output | 1 | Slave clock input to the link |
| spiSlaveSel | output | 1 | Slave selected (SS pin low in slave mode) |
| cmpEnable | input | 4 | Compare-output enables for pins 7..4 |
| cmpValue | input | 4 | Compare-output values for pins 7..4 |
| padIn | input | 8 | Pad input levels |
| padOe | output | 8 | Pad output enables |
| padOut | output | 8 | Pad output values |
| padPullUp | output | 8 | Pad pull-up enables |
| pinChange | output | 8 | Qualified pin-change sources |

## Verification
The assertions check the following on every cycle:
- the forced-input rules for the serial link in both modes;
- that the SS pad output always follows its register bit;
- that an enabled compare output always reaches its pad value;
- that pin-change sources never rise outside the mask and group enable;
- that writes to the readback address are ignored.

Some behaviours can only be shown by the bench's scenarios:
- the two-edge latency of the synchronizer;
- input gating under the low-power request;
- slave selection following the synchronized SS level;
- the pull-up values under `pullUpDisable`.

To cover these, the bench mixes directed cases with randomly drawn combinations of mode, register contents and pad levels. It compares every pad control output against a reference model.

// File: rtl/gpioAltPkg.sv
package gpioAltPkg;
  localparam int PIN_COUNT = 8;
  localparam int ADDR_W    = 3;
  localparam int CMP_BASE  = 4;
  localparam int CMP_COUNT = PIN_COUNT - CMP_BASE;

  localparam int PIN_SS   = 0;
  localparam int PIN_SCK  = 1;
  localparam int PIN_MOSI = 2;
  localparam int PIN_MISO = 3;

  localparam logic [ADDR_W-1:0] ADDR_DIR  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PORT = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_PIN  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 3'd3;

  typedef enum logic [1:0] {
    RD_DIR  = 2'd0,
    RD_PORT = 2'd1,
    RD_PIN  = 2'd2,
    RD_MASK = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrDir;
    logic   wrPort;
    logic   wrMask;
    logic   rdValid;
    rdSel_e rdSel;
  } portStrobes_t;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpioAltPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output portStrobes_t      strobes
);
  always_comb begin
    strobes = '0;
    strobes.rdSel = RD_DIR;
    case (busAddr)
      ADDR_DIR: begin
        strobes.rdValid = 1'b1;
        strobes.rdSel   = RD_DIR;
        strobes.wrDir   = busWe;
      end
      ADDR_PORT: begin
        strobes.rdValid = 1'b1;
        strobes.rdSel   = RD_PORT;
        strobes.wrPort  = busWe;
      end
      ADDR_PIN: begin
        strobes.rdValid = 1'b1;
        strobes.rdSel   = RD_PIN;
      end
      ADDR_MASK: begin
        strobes.rdValid = 1'b1;
        strobes.rdSel   = RD_MASK;
        strobes.wrMask  = busWe;
      end
      default: strobes.rdValid = 1'b0;
    endcase
  end

  // R2
  pin_readonly_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_PIN) |-> !(strobes.wrDir || strobes.wrPort || strobes.wrMask));

  // R2
  one_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrDir, strobes.wrPort, strobes.wrMask}));
endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpioAltPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  portStrobes_t         strobes,
  input  logic [PIN_COUNT-1:0] busWdata,
  output logic [PIN_COUNT-1:0] busRdata,
  input  logic                 pullUpDisable,
  input  logic                 pcGroupEn,
  input  logic                 inputsOff,
  input  logic                 spiEnable,
  input  logic                 spiMaster,
  input  logic                 spiMisoOut,
  input  logic                 spiMosiOut,
  input  logic                 spiSckOut,
  output logic                 spiMisoIn,
  output logic                 spiMosiIn,
  output logic                 spiSckIn,
  output logic                 spiSlaveSel,
  input  logic [CMP_COUNT-1:0] cmpEnable,
  input  logic [CMP_COUNT-1:0] cmpValue,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padPullUp,
  output logic [PIN_COUNT-1:0] pinChange
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [PIN_COUNT-1:0] dirReg, portReg, maskReg;
  logic [PIN_COUNT-1:0] syncQ [SYNC_STAGES];
  logic [PIN_COUNT-1:0] pinSync;

  logic [PIN_COUNT-1:0] puOvrEn, puOvrVal, dirOvrEn, dirOvrVal;
  logic [PIN_COUNT-1:0] outOvrEn, outOvrVal, dieOvrEn, dieOvrVal;
  logic [PIN_COUNT-1:0] dirEff, outEff, puEff, dieEff;

  logic spiMst, spiSlv;
  assign spiMst = spiEnable & spiMaster;
  assign spiSlv = spiEnable & ~spiMaster;

  // software registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= '0;
      portReg <= '0;
      maskReg <= '0;
    end else begin
      if (strobes.wrDir)  dirReg  <= busWdata;
      if (strobes.wrPort) portReg <= busWdata;
      if (strobes.wrMask) maskReg <= busWdata;
    end
  end

  // per-pin override sources
  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    assign dieOvrEn[i]  = maskReg[i] & pcGroupEn;
    assign dieOvrVal[i] = 1'b1;

    if (i >= CMP_BASE) begin : g_cmp
      assign puOvrEn[i]   = 1'b0;
      assign puOvrVal[i]  = 1'b0;
      assign dirOvrEn[i]  = 1'b0;
      assign dirOvrVal[i] = 1'b0;
      assign outOvrEn[i]  = cmpEnable[i-CMP_BASE];
      assign outOvrVal[i] = cmpValue[i-CMP_BASE];
    end else if (i == PIN_MISO) begin : g_miso
      assign puOvrEn[i]   = spiMst;
      assign puOvrVal[i]  = portReg[i] & ~pullUpDisable;
      assign dirOvrEn[i]  = spiMst;
      assign dirOvrVal[i] = 1'b0;
      assign outOvrEn[i]  = spiSlv;
      assign outOvrVal[i] = spiMisoOut;
    end else begin : g_slvIn
      assign puOvrEn[i]   = spiSlv;
      assign puOvrVal[i]  = portReg[i] & ~pullUpDisable;
      assign dirOvrEn[i]  = spiSlv;
      assign dirOvrVal[i] = 1'b0;
      if (i == PIN_MOSI) begin : g_mosi
        assign outOvrEn[i]  = spiMst;
        assign outOvrVal[i] = spiMosiOut;
      end else if (i == PIN_SCK) begin : g_sck
        assign outOvrEn[i]  = spiMst;
        assign outOvrVal[i] = spiSckOut;
      end else begin : g_ss
        assign outOvrEn[i]  = 1'b0;
        assign outOvrVal[i] = 1'b0;
      end
    end

    assign dirEff[i] = dirOvrEn[i] ? dirOvrVal[i] : dirReg[i];
    assign outEff[i] = outOvrEn[i] ? outOvrVal[i] : portReg[i];
    assign puEff[i]  = puOvrEn[i]  ? puOvrVal[i]  : (portReg[i] & ~pullUpDisable);
    assign dieEff[i] = dieOvrEn[i] ? dieOvrVal[i] : ~inputsOff;
  end

  assign padOe     = dirEff;
  assign padOut    = outEff;
  assign padPullUp = ~dirEff & puEff;

  // input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= padIn & dieEff;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end
  assign pinSync = syncQ[LAST_STAGE];

  assign pinChange   = pinSync & maskReg & {PIN_COUNT{pcGroupEn}};
  assign spiMisoIn   = pinSync[PIN_MISO];
  assign spiMosiIn   = pinSync[PIN_MOSI];
  assign spiSckIn    = pinSync[PIN_SCK];
  assign spiSlaveSel = spiSlv & ~pinSync[PIN_SS];

  // bus read
  always_comb begin
    busRdata = '0;
    if (strobes.rdValid) begin
      case (strobes.rdSel)
        RD_DIR:  busRdata = dirReg;
        RD_PORT: busRdata = portReg;
        RD_PIN:  busRdata = pinSync;
        RD_MASK: busRdata = maskReg;
        default: busRdata = '0;
      endcase
    end
  end

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrDir |=> dirReg == $past(busWdata));

  // R4
  master_miso_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spiEnable && spiMaster) |-> !padOe[PIN_MISO]);

  // R5
  slave_inputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spiEnable && !spiMaster) |-> (padOe[PIN_MISO-1:0] == '0));

  // R6
  ss_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    padOut[PIN_SS] == portReg[PIN_SS]);

  // R10
  pin_change_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinChange & ~(maskReg & {PIN_COUNT{pcGroupEn}})) == '0);

  for (genvar k = 0; k < CMP_COUNT; k++) begin : g_cmpChk
    // R7
    cmp_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
      cmpEnable[k] |-> (padOut[CMP_BASE+k] == cmpValue[k]));
  end
endmodule

// File: rtl/gpio_alt_port.sv
module gpio_alt_port
  import gpioAltPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] busAddr,
  input  logic       busWe,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       pullUpDisable,
  input  logic       pcGroupEn,
  input  logic       inputsOff,
  input  logic       spiEnable,
  input  logic       spiMaster,
  input  logic       spiMisoOut,
  input  logic       spiMosiOut,
  input  logic       spiSckOut,
  output logic       spiMisoIn,
  output logic       spiMosiIn,
  output logic       spiSckIn,
  output logic       spiSlaveSel,
  input  logic [3:0] cmpEnable,
  input  logic [3:0] cmpValue,
  input  logic [7:0] padIn,
  output logic [7:0] padOe,
  output logic [7:0] padOut,
  output logic [7:0] padPullUp,
  output logic [7:0] pinChange
);
  portStrobes_t strobes;

  gpio_port_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobes (strobes)
  );

  gpio_port_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .busWdata      (busWdata),
    .busRdata      (busRdata),
    .pullUpDisable (pullUpDisable),
    .pcGroupEn     (pcGroupEn),
    .inputsOff     (inputsOff),
    .spiEnable     (spiEnable),
    .spiMaster     (spiMaster),
    .spiMisoOut    (spiMisoOut),
    .spiMosiOut    (spiMosiOut),
    .spiSckOut     (spiSckOut),
    .spiMisoIn     (spiMisoIn),
    .spiMosiIn     (spiMosiIn),
    .spiSckIn      (spiSckIn),
    .spiSlaveSel   (spiSlaveSel),
    .cmpEnable     (cmpEnable),
    .cmpValue      (cmpValue),
    .padIn         (padIn),
    .padOe         (padOe),
    .padOut        (padOut),
    .padPullUp     (padPullUp),
    .pinChange     (pinChange)
  );
endmodule

// File: tb/sim_gpio_alt_port.sv
`timescale 1ns/1ps
module sim_gpio_alt_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       pullUpDisable = 1'b0, pcGroupEn = 1'b0, inputsOff = 1'b0;
  logic       spiEnable = 1'b0, spiMaster = 1'b0;
  logic       spiMisoOut = 1'b0, spiMosiOut = 1'b0, spiSckOut = 1'b0;
  logic       spiMisoIn, spiMosiIn, spiSckIn, spiSlaveSel;
  logic [3:0] cmpEnable = '0, cmpValue = '0;
  logic [7:0] padIn = '0;
  logic [7:0] padOe, padOut, padPullUp, pinChange;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0] mDir = '0, mPort = '0, mMask = '0, s1 = '0, s2 = '0;

  always #2.5 clk = ~clk;

  gpio_alt_port u0 (.*);

  function automatic logic [7:0] expDirEff();
    logic [7:0] d = mDir;
    if (spiEnable && spiMaster)  d[3] = 1'b0;
    if (spiEnable && !spiMaster) d[2:0] = 3'b000;
    return d;
  endfunction

  function automatic logic [7:0] expOut();
    logic [7:0] o = mPort;
    for (int k = 0; k < 4; k++) if (cmpEnable[k]) o[4+k] = cmpValue[k];
    if (spiEnable && !spiMaster) o[3] = spiMisoOut;
    if (spiEnable && spiMaster) begin
      o[2] = spiMosiOut;
      o[1] = spiSckOut;
    end
    return o;
  endfunction

  function automatic logic [7:0] expPu();
    return ~expDirEff() & mPort & {8{~pullUpDisable}};
  endfunction

  function automatic logic [7:0] expDie();
    return {8{~inputsOff}} | (mMask & {8{pcGroupEn}});
  endfunction

  function automatic logic [7:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return mDir;
      3'd1: return mPort;
      3'd2: return s2;
      3'd3: return mMask;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock edge, with the reference model advanced at that edge
  task automatic step();
    logic [7:0] gated;
    @(posedge clk);
    gated = padIn & expDie();
    s2 = s1;
    s1 = gated;
    if (busWe) begin
      case (busAddr)
        3'd0: mDir  = busWdata;
        3'd1: mPort = busWdata;
        3'd3: mMask = busWdata;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    step();
    busWe = 1'b0;
  endtask

  task automatic checkPads(input string tag);
    check({tag, " padOe"},     padOe,     expDirEff());
    check({tag, " padOut"},    padOut,    expOut());
    check({tag, " padPullUp"}, padPullUp, expPu());
  endtask

  task automatic readCheck(input string tag, input logic [2:0] a);
    busAddr = a;
    #0.1;
    check(tag, busRdata, expRead(a));
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 padOe", padOe, 8'h00);
    check("R1 padPullUp", padPullUp, 8'h00);
    readCheck("R1 dir", 3'd0);
    readCheck("R1 port", 3'd1);
    readCheck("R1 pin", 3'd2);
    readCheck("R1 mask", 3'd3);

    // R2 register access
    busWrite(3'd0, 8'hA5);
    busWrite(3'd1, 8'h3C);
    busWrite(3'd3, 8'h0F);
    readCheck("R2 dir", 3'd0);
    readCheck("R2 port", 3'd1);
    readCheck("R2 mask", 3'd3);
    busWrite(3'd2, 8'hFF);
    readCheck("R2 pin readonly", 3'd2);
    readCheck("R2 dir after pin write", 3'd0);
    readCheck("R2 port after pin write", 3'd1);
    readCheck("R2 unmapped", 3'd5);

    // R3 plain pins, with and without global pull-up disable
    checkPads("R3 plain");
    check("R3 pullup exact", padPullUp, 8'h18);
    pullUpDisable = 1'b1; #0.1;
    check("R3 pud", padPullUp, 8'h00);
    pullUpDisable = 1'b0;

    // R4 master mode
    busWrite(3'd0, 8'hFF);
    busWrite(3'd1, 8'h0F);
    spiEnable = 1'b1; spiMaster = 1'b1;
    spiMosiOut = 1'b0; spiSckOut = 1'b1; #0.1;
    check("R4 miso forced input", {7'd0, padOe[3]}, 8'h00);
    check("R4 miso pullup", {7'd0, padPullUp[3]}, 8'h01);
    check("R4 mosi/sck value", {6'd0, padOut[2:1]}, 8'h01);
    check("R4 mosi/sck dir", {6'd0, padOe[2:1]}, 8'h03);
    checkPads("R4");

    // R5 slave mode
    spiMaster = 1'b0; spiMisoOut = 1'b0; #0.1;
    check("R5 slave inputs", {5'd0, padOe[2:0]}, 8'h00);
    check("R5 slave pullups", {5'd0, padPullUp[2:0]}, 8'h07);
    check("R5 miso drive", {6'd0, padOe[3], padOut[3]}, 8'h02);
    checkPads("R5");

    // R6 SS value never overridden
    busWrite(3'd1, 8'h00);
    spiMaster = 1'b1; spiMosiOut = 1'b1; spiSckOut = 1'b1; #0.1;
    check("R6 ss master", {7'd0, padOut[0]}, 8'h00);
    spiMaster = 1'b0; #0.1;
    check("R6 ss slave", {7'd0, padOut[0]}, 8'h00);
    spiEnable = 1'b0;

    // R7 compare pins
    busWrite(3'd1, 8'hF0);
    busWrite(3'd0, 8'h30);
    cmpEnable = 4'b0101; cmpValue = 4'b0000; #0.1;
    check("R7 cmp value", padOut, 8'hA0);
    check("R7 cmp dir", padOe, 8'h30);
    check("R7 cmp pullup", padPullUp, 8'hC0);
    cmpEnable = '0;

    // R8 two-edge synchronizer
    busWrite(3'd0, 8'h00);
    padIn = 8'h5A;
    step();
    readCheck("R8 one edge", 3'd2);
    check("R8 one edge exact", busRdata, 8'h00);
    step();
    readCheck("R8 two edges", 3'd2);
    check("R8 two edges exact", busRdata, 8'h5A);
    check("R12 miso in", {7'd0, spiMisoIn}, 8'h01);
    check("R12 mosi in", {7'd0, spiMosiIn}, 8'h00);
    check("R12 sck in", {7'd0, spiSckIn}, 8'h01);

    // R9 / R10 input gating and pin-change
    busWrite(3'd3, 8'h0F);
    inputsOff = 1'b1; pcGroupEn = 1'b1; padIn = 8'hFF;
    step(); step();
    readCheck("R9 masked kept", 3'd2);
    check("R9 exact", busRdata, 8'h0F);
    check("R10 pin change", pinChange, 8'h0F);
    pcGroupEn = 1'b0;
    step(); step();
    readCheck("R9 group off", 3'd2);
    check("R9 group off exact", busRdata, 8'h00);
    check("R10 group off", pinChange, 8'h00);
    inputsOff = 1'b0;

    // R11 slave select
    spiEnable = 1'b1; spiMaster = 1'b0; padIn = 8'h00;
    step(); step();
    check("R11 ss low", {7'd0, spiSlaveSel}, 8'h01);
    spiMaster = 1'b1; #0.1;
    check("R11 master not selected", {7'd0, spiSlaveSel}, 8'h00);
    spiMaster = 1'b0; padIn = 8'h01;
    step(); step();
    check("R11 ss high", {7'd0, spiSlaveSel}, 8'h00);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom();
      spiEnable     = r[0];
      spiMaster     = r[1];
      spiMisoOut    = r[2];
      spiMosiOut    = r[3];
      spiSckOut     = r[4];
      pullUpDisable = r[5];
      pcGroupEn     = r[6];
      inputsOff     = r[7];
      cmpEnable     = r[11:8];
      cmpValue      = r[15:12];
      padIn         = r[23:16];
      busWe         = (r[26:24] < 3'd3);
      busAddr       = r[29:27];
      busWdata      = 8'($urandom());
      step();
      checkPads("R3 random");
      check("R10 random", pinChange, s2 & mMask & {8{pcGroupEn}});
      check("R11 random", {7'd0, spiSlaveSel}, {7'd0, spiEnable & ~spiMaster & ~s2[0]});
      check("R12 random", {5'd0, spiMisoIn, spiMosiIn, spiSckIn}, {5'd0, s2[3:1]});
      check("R2 random read", busRdata, expRead(busAddr));
    end
    busWe = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule